// File: doc/BRIEF.md
# ALU Flag and Condition Unit

This unit is the arithmetic and status slice of a 32-bit processor execute stage. It adds two operands with a carry-in, or subtracts them, or forms a bitwise AND or OR. The result leaves the unit in the same cycle. From that result it derives the negative, zero, carry and overflow status flags and keeps them in a small register.

Subtraction uses the same adder as addition, with the second operand inverted. For a plain subtract the caller supplies a carry-in of 1, so the carry flag reads as "no borrow". For the logical operations the carry flag comes from an external shifter, and the overflow flag keeps its value.

The flags are written only when the instruction's set-flags bit is 1 or when the core is in its compact instruction mode. A saved status word can be written back into the flag register through a direct port, and that write wins over any ALU update in the same cycle. A 4-bit condition code is evaluated against the stored flags to decide whether an instruction executes or is skipped.

Top module: `alu_flag_unit`

## Requirements
- R1: With op = 0 (add), result equals a + b + carry_in modulo 2^32, in the same cycle.
- R2: With op = 1 (subtract), result equals a + ~b + carry_in modulo 2^32, so a = b with carry_in = 1 gives 0.
- R3: After an arithmetic update, V (flags bit 0) is 1 exactly when both operands fed to the adder (a and b, or a and ~b) have the same sign and the result's sign differs from it.
- R4: After an arithmetic update, C (flags bit 1) equals the carry out of bit 31 of the 33-bit sum.
- R5: After any update, N (flags bit 3) equals result bit 31 and Z (flags bit 2) is 1 exactly when the result is zero.
- R6: With op = 2 (AND) or op = 3 (OR), result is the bitwise function of a and b, C takes shift_carry, and V keeps its previous value.
- R7: The flags change on a clock edge only when set_flags or compact_mode is 1, or when restore_en is 1; otherwise they hold.
- R8: A synchronous active-high rst clears all four flags to 0.
- R9: When restore_en is 1, the next flags equal restore_flags ({N,Z,C,V}), whatever the ALU update inputs are.
- R10: Condition codes 0 to 7 test single flags: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0.
- R11: Condition codes 8 to 13 are compound tests: 8 C=1 and Z=0; 9 C=0 or Z=1; 10 N=V; 11 N!=V; 12 Z=0 and N=V; 13 Z=1 or N!=V.
- R12: Condition code 14 always passes and code 15 never passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| carry_in | input | 1 | Adder carry-in |
| op | input | 2 | 0 add, 1 subtract, 2 AND, 3 OR |
| set_flags | input | 1 | Set-flags bit of the instruction |
| compact_mode | input | 1 | Compact-mode qualifier; forces a flag update |
| shift_carry | input | 1 | Shifter carry-out, used as C for the logical operations |
| restore_en | input | 1 | Write restore_flags into the flag register |
| restore_flags | input | 4 | Saved status word {N,Z,C,V} |
| cond | input | 4 | Condition code to evaluate |
| result | output | 32 | Operation result (combinational) |
| flags | output | 4 | Registered flags {N,Z,C,V} |
| cond_pass | output | 1 | 1 when cond passes against the registered flags |

## Verification
The result is combinational, so it is due in the same cycle as its operands. The flags appear one clock edge later. cond_pass is combinational from the registered flags and the current code. The driver changes the inputs on the falling edge and queues one expected item. The monitor waits until just after the next rising edge, and there it compares the result (inputs still held), the updated flags, and the condition outcome computed from the expected flags against the held code. The expected flags come from a separate model built on 33-bit sums.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
    localparam int DATA_W = 32;
    localparam int COND_W = 4;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    input  alu_op_e          op,
    input  logic             shift_carry,
    input  logic             v_prev,
    output logic [WIDTH-1:0] result,
    output nzcv_t            new_flags
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   sum;
    logic [WIDTH-1:0] ovf_vec;
    logic             is_logic;

    always_comb begin
        is_logic = (op == OP_AND) || (op == OP_OR);
        b_eff    = (op == OP_SUB) ? ~b : b;
        sum      = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, carry_in};
        ovf_vec  = ~(a ^ b_eff) & (a ^ sum[MSB:0]);
        unique case (op)
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            default: result = sum[MSB:0];
        endcase
        new_flags.n = result[MSB];
        new_flags.z = (result == '0);
        if (is_logic) begin
            new_flags.c = shift_carry;
            new_flags.v = v_prev;
        end else begin
            new_flags.c = ovf_vec[MSB] ^ a[MSB] ^ b_eff[MSB] ^ sum[MSB];
            new_flags.v = ovf_vec[MSB];
        end
    end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import alu_flag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  update,
    input  nzcv_t alu_flags,
    input  logic  restore_en,
    input  nzcv_t restore_val,
    output nzcv_t flags
);
    typedef struct packed {
        nzcv_t flags;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (restore_en) begin
            state_d.flags = restore_val;
        end else if (update) begin
            state_d.flags = alu_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags = state_q.flags;
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import alu_flag_pkg::*;
(
    input  logic [COND_W-1:0] code,
    input  nzcv_t             flags,
    output logic              pass
);
    localparam int GROUPS = 1 << (COND_W - 1);

    logic [GROUPS-1:0] base;

    always_comb begin
        base[0] = flags.z;
        base[1] = flags.c;
        base[2] = flags.n;
        base[3] = flags.v;
        base[4] = flags.c & ~flags.z;
        base[5] = (flags.n == flags.v);
        base[6] = ~flags.z & (flags.n == flags.v);
        base[7] = 1'b1;
        pass = base[code[COND_W-1:1]] ^ code[0];
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    input  logic              carry_in,
    input  logic [1:0]        op,
    input  logic              set_flags,
    input  logic              compact_mode,
    input  logic              shift_carry,
    input  logic              restore_en,
    input  logic [3:0]        restore_flags,
    input  logic [COND_W-1:0] cond,
    output logic [WIDTH-1:0]  result,
    output logic [3:0]        flags,
    output logic              cond_pass
);
    nzcv_t   flags_q;
    nzcv_t   alu_flags;
    alu_op_e op_sel;
    logic    update;

    assign op_sel = alu_op_e'(op);
    assign update = set_flags | compact_mode;

    alu_datapath #(.WIDTH(WIDTH)) u_dp (
        .a           (a),
        .b           (b),
        .carry_in    (carry_in),
        .op          (op_sel),
        .shift_carry (shift_carry),
        .v_prev      (flags_q.v),
        .result      (result),
        .new_flags   (alu_flags)
    );

    flag_reg u_flags (
        .clk         (clk),
        .rst         (rst),
        .update      (update),
        .alu_flags   (alu_flags),
        .restore_en  (restore_en),
        .restore_val (nzcv_t'(restore_flags)),
        .flags       (flags_q)
    );

    cond_eval u_cond (
        .code  (cond),
        .flags (flags_q),
        .pass  (cond_pass)
    );

    assign flags = flags_q;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             carry_in,
    input logic [1:0]       op,
    input logic             set_flags,
    input logic             compact_mode,
    input logic             shift_carry,
    input logic             restore_en,
    input logic [3:0]       restore_flags,
    input logic [3:0]       cond,
    input logic [WIDTH-1:0] result,
    input logic [3:0]       flags,
    input logic             cond_pass
);
    logic [WIDTH:0] wide;
    logic           upd;

    always_comb begin
        if (op == 2'd1) wide = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, !carry_in} + {1'b1, {WIDTH{1'b0}}};
        else            wide = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_in};
        upd = (set_flags || compact_mode) && !restore_en;
    end

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_flags && !compact_mode && !restore_en) |=> $stable(flags));

    a_r9_restore: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> (flags == $past(restore_flags)));

    a_r6_v_kept: assert property (@(posedge clk) disable iff (rst)
        (upd && op[1]) |=> (flags[0] == $past(flags[0])));

    a_r6_c_shift: assert property (@(posedge clk) disable iff (rst)
        (upd && op[1]) |=> (flags[1] == $past(shift_carry)));

    a_r4_carry: assert property (@(posedge clk) disable iff (rst)
        (upd && !op[1]) |=> (flags[1] == $past(wide[WIDTH])));

    a_r5_zero: assert property (@(posedge clk) disable iff (rst)
        upd |=> (flags[2] == ($past(result) == '0)));

    a_r12_always: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'd14) |-> cond_pass);

    a_r12_never: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'd15) |-> !cond_pass);
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_flag_unit_bench.sv
`timescale 1ns/1ps
module alu_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a = '0, b = '0;
    logic        carry_in = 1'b0;
    logic [1:0]  op = '0;
    logic        set_flags = 1'b0, compact_mode = 1'b0, shift_carry = 1'b0;
    logic        restore_en = 1'b0;
    logic [3:0]  restore_flags = '0;
    logic [3:0]  cond = 4'd14;
    logic [31:0] result;
    logic [3:0]  flags;
    logic        cond_pass;

    int vectors = 0;
    int errors  = 0;
    logic [3:0] mflags = 4'd0;

    typedef struct {
        logic [31:0] res;
        logic [3:0]  fl;
        logic        pass;
        logic [3:0]  code;
        logic [1:0]  op;
        int          kind; // 0 ALU update, 1 hold, 2 restore, 3 reset
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;

    alu_flag_unit u_alu_flag_unit (.*);

    function automatic logic cond_model(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] ia, input logic [31:0] ib, input logic icin,
                         input logic [1:0] iop, input logic is, input logic icm,
                         input logic isc, input logic irs, input logic [3:0] irv,
                         input logic [3:0] icond, input logic irst);
        item_t it;
        logic [32:0] s;
        logic [31:0] bb, r;
        logic [3:0]  nf;
        @(negedge clk);
        a = ia; b = ib; carry_in = icin; op = iop; set_flags = is; compact_mode = icm;
        shift_carry = isc; restore_en = irs; restore_flags = irv; cond = icond; rst = irst;
        bb = (iop == 2'd1) ? ~ib : ib;
        s  = {1'b0, ia} + {1'b0, bb} + {32'd0, icin};
        if (iop == 2'd2)      r = ia & ib;
        else if (iop == 2'd3) r = ia | ib;
        else                  r = s[31:0];
        nf = mflags;
        it.kind = 1;
        if (irst) begin
            nf = 4'd0; it.kind = 3;
        end else if (irs) begin
            nf = irv; it.kind = 2;
        end else if (is || icm) begin
            it.kind = 0;
            nf[3] = r[31];
            nf[2] = (r == 32'd0);
            if (iop[1]) begin
                nf[1] = isc;
            end else begin
                nf[1] = s[32];
                nf[0] = (ia[31] == bb[31]) && (r[31] != ia[31]);
            end
        end
        mflags  = nf;
        it.res  = r;
        it.fl   = nf;
        it.code = icond;
        it.op   = iop;
        it.pass = cond_model(icond, nf);
        q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                if (it.kind != 3) begin
                    if (it.op == 2'd0)      check(result == it.res, "R1 add result", result, it.res);
                    else if (it.op == 2'd1) check(result == it.res, "R2 sub result", result, it.res);
                    else                    check(result == it.res, "R6 logic result", result, it.res);
                end
                case (it.kind)
                    3: check(flags == 4'd0, "R8 reset flags", {28'd0, flags}, 32'd0);
                    2: check(flags == it.fl, "R9 restore flags", {28'd0, flags}, {28'd0, it.fl});
                    1: check(flags == it.fl, "R7 flags held", {28'd0, flags}, {28'd0, it.fl});
                    default: begin
                        check(flags[3:2] == it.fl[3:2], "R5 N/Z flags", {30'd0, flags[3:2]}, {30'd0, it.fl[3:2]});
                        if (it.op[1]) begin
                            check(flags[1:0] == it.fl[1:0], "R6 C/V flags", {30'd0, flags[1:0]}, {30'd0, it.fl[1:0]});
                        end else begin
                            check(flags[1] == it.fl[1], "R4 carry flag", {31'd0, flags[1]}, {31'd0, it.fl[1]});
                            check(flags[0] == it.fl[0], "R3 overflow flag", {31'd0, flags[0]}, {31'd0, it.fl[0]});
                        end
                    end
                endcase
                if (it.code < 4'd8)       check(cond_pass == it.pass, "R10 single-flag cond", {31'd0, cond_pass}, {31'd0, it.pass});
                else if (it.code < 4'd14) check(cond_pass == it.pass, "R11 compound cond", {31'd0, cond_pass}, {31'd0, it.pass});
                else                      check(cond_pass == it.pass, "R12 always/never cond", {31'd0, cond_pass}, {31'd0, it.pass});
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : driver
        // R8: reset state, checked directly
        @(negedge clk);
        @(negedge clk);
        check(flags == 4'd0, "R8 flags after reset", {28'd0, flags}, 32'd0);
        rst = 1'b0;
        // R1/R3/R4/R5 boundary additions
        apply(32'h7FFFFFFF, 32'h00000001, 0, 2'd0, 1, 0, 0, 0, 0, 4'd6, 0);
        apply(32'hFFFFFFFF, 32'h00000001, 0, 2'd0, 1, 0, 0, 0, 0, 4'd0, 0);
        apply(32'h80000000, 32'h80000000, 0, 2'd0, 0, 1, 0, 0, 0, 4'd2, 0);
        apply(32'hFFFFFFFF, 32'hFFFFFFFF, 1, 2'd0, 1, 0, 0, 0, 0, 4'd8, 0);
        // R2 subtracts
        apply(32'h00000000, 32'h00000001, 1, 2'd1, 1, 0, 0, 0, 0, 4'd3, 0);
        apply(32'h12345678, 32'h12345678, 1, 2'd1, 1, 0, 0, 0, 0, 4'd0, 0);
        apply(32'h80000000, 32'h00000001, 1, 2'd1, 1, 0, 0, 0, 0, 4'd6, 0);
        apply(32'h7FFFFFFF, 32'hFFFFFFFF, 1, 2'd1, 1, 0, 0, 0, 0, 4'd11, 0);
        // R6 logical, V kept
        apply(32'hF0F0F0F0, 32'h0F0F0F0F, 0, 2'd2, 1, 0, 1, 0, 0, 4'd0, 0);
        apply(32'h80000000, 32'h00000001, 0, 2'd3, 1, 0, 0, 0, 0, 4'd4, 0);
        // R7 hold without qualifiers
        apply(32'h00000000, 32'h00000000, 0, 2'd0, 0, 0, 1, 0, 0, 4'd1, 0);
        apply(32'hFFFFFFFF, 32'h00000001, 0, 2'd2, 0, 0, 1, 0, 0, 4'd5, 0);
        // R9 restore beats update
        apply(32'h00000000, 32'h00000000, 0, 2'd0, 1, 1, 0, 1, 4'b1011, 4'd13, 0);
        // R10/R11/R12 every code against every flag pattern
        for (int f = 0; f < 16; f++) begin
            for (int c = 0; c < 16; c++) begin
                apply(32'd5, 32'd3, 0, 2'd0, 0, 0, 0, 1, f[3:0], c[3:0], 0);
            end
        end
        // R8 reset mid-run
        apply(32'h7FFFFFFF, 32'h1, 0, 2'd0, 1, 0, 0, 0, 0, 4'd14, 0);
        apply(32'h0, 32'h0, 0, 2'd0, 1, 0, 0, 1, 4'hF, 4'd15, 1);
        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (i % 7 == 0) ra = 32'h80000000;
            if (i % 11 == 0) rb = 32'hFFFFFFFF;
            apply(ra, rb, 1'($urandom()), 2'($urandom()), 1'($urandom()), 1'($urandom() % 4 == 0),
                  1'($urandom()), 1'($urandom() % 9 == 0), 4'($urandom()), 4'($urandom()), 0);
        end
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule